// File: doc/BRIEF.md
# Rank Clock-Enable Power-Down Controller

This block sits beside a DRAM command scheduler and decides, for every memory rank on its own, when the clock-enable line of that rank may be dropped and which kind of power-down to use. Each rank keeps an idle timer that restarts on every transaction arrival for that rank. When the timer runs out and nothing is queued for the rank, the rank powers down in the flavour chosen by the mode setting. Some flavours first ask the scheduler to close all banks through a precharge-all request and acknowledge handshake. In the two hybrid flavours the rank first enters active power-down. Once every page-close timer of the rank has run out, the rank is woken, precharged and sent into a deeper power-down.

Wake-up is immediate. A transaction arrival, a pending transaction or a refresh request raises clock-enable in the next cycle. The rank's issue permission stays blocked until the exit delay has elapsed, and that delay is longer when the rank leaves a DLL-off power-down. When a refresh is due, all ranks are brought up and a ready flag is raised. When the request drops, the ranks power down again. When the package reports deep idle and no memory request is pending anywhere, every rank is put into self-refresh. After reset, clock-enable stays low until a configuration release arrives. Ranks marked unpopulated never drive clock-enable.

Top module: `cke_pd_ctrl`

## Requirements
- R1: After reset every `cke` and `issue_ok` bit is 0, and they stay 0 until a cycle in which `cfg_cke_release` is 1 has been seen. That release is sticky until the next reset.
- R2: A rank whose `rank_populated` bit is 0 has `cke`, `issue_ok`, `pre_all_req` and `dll_off_sel` all 0.
- R3: The idle counter of a rank restarts at 0 on every cycle in which `txn_arrive` is set for that rank, and otherwise counts up to `cfg_idle_limit`. A rank can start a power-down only in the cycle after its count has reached the limit, and only while its `txn_pending` and `txn_arrive` bits are 0 and `refresh_req` is 0.
- R4: With mode 0 (no power-down), a released populated rank keeps `cke` at 1 unless it is in self-refresh.
- R5: With mode 1 (active power-down), an expired rank drops `cke` in the next cycle without raising `pre_all_req`.
- R6: With mode 2 (precharge power-down) or mode 3 (DLL-off power-down), an expired rank raises `pre_all_req` with `cke` still 1. It drops `cke` in the cycle after `pre_all_ack`. In mode 3, `dll_off_sel` is 1 while the rank is powered down.
- R7: With mode 4 (active, then precharge) or mode 5 (active, then DLL-off), a rank in active power-down whose `pages_closed_all` bit is 1 is woken. After the short exit delay it raises `pre_all_req`, and on acknowledge it enters the precharge power-down (mode 4) or the DLL-off power-down (mode 5).
- R8: An arrival, a pending transaction or a refresh request on a powered-down rank raises `cke` in the next cycle. `issue_ok` then stays 0 for `T_XP` cycles, or for `T_XP + T_XPDLL` cycles after a DLL-off power-down or self-refresh.
- R9: While `refresh_req` is 1, ranks are woken and kept up. `refresh_ready` is 1 exactly when every populated released rank has `issue_ok` set. After `refresh_req` falls, ranks whose timers have expired power down again.
- R10: When `pkg_deep_idle` is 1 and no rank has `txn_pending` or `txn_arrive` set, every released populated rank enters self-refresh in the next cycle with `cke` 0, and `sref_active` is 1.
- R11: Mode codes 6 and 7 behave like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cke_release | input | 1 | Configuration release of clock-enable (sticky) |
| cfg_pd_mode | input | 3 | Power-down mode code 0..5 |
| cfg_idle_limit | input | 8 | Idle cycles before power-down |
| rank_populated | input | NUM_RANKS | Population mask |
| txn_arrive | input | NUM_RANKS | Transaction arrival pulse per rank |
| txn_pending | input | NUM_RANKS | Transaction queued per rank |
| pages_closed_all | input | NUM_RANKS | All page-close timers of the rank expired |
| refresh_req | input | 1 | Refresh due |
| refresh_ready | output | 1 | All ranks up for refresh |
| pkg_deep_idle | input | 1 | Package in deep idle |
| pre_all_req | output | NUM_RANKS | Precharge-all request to the scheduler |
| pre_all_ack | input | NUM_RANKS | Precharge-all done |
| cke | output | NUM_RANKS | Clock-enable per rank |
| issue_ok | output | NUM_RANKS | Scheduler may issue to the rank |
| dll_off_sel | output | NUM_RANKS | Rank is in DLL-off power-down |
| sref_active | output | 1 | Some rank is in self-refresh |

## Verification
The bench builds the block with two ranks, `T_XP` = 3 and `T_XPDLL` = 10, and programs idle limits between 15 and 22. With these values every power-down, wake and hybrid deepening completes within a few dozen cycles, so thousands of full cycles fit into one run. Two ranks are enough to bring mixed population masks, refresh gathering with one rank still in its exit delay, and self-refresh of both ranks within reach. The short DLL delay keeps the long exit window visibly different from the short one.

// File: rtl/cke_pd_pkg.sv
// Shared encodings for the rank power-down controller.
// Assumes: mode codes are fixed by configuration software.
package cke_pd_pkg;
    typedef enum logic [2:0] {
        PD_MODE_NONE    = 3'd0,
        PD_MODE_ACTIVE  = 3'd1,
        PD_MODE_PRECH   = 3'd2,
        PD_MODE_DLLOFF  = 3'd3,
        PD_MODE_ACT2PRE = 3'd4,
        PD_MODE_ACT2DLL = 3'd5
    } pd_mode_e;

    typedef enum logic [2:0] {
        RK_OFF, RK_UP, RK_PRE, RK_APD, RK_PPD, RK_DLL, RK_WAKE, RK_SREF
    } rank_st_e;
endpackage

// File: rtl/cke_idle_timer.sv
// Per-rank idle timer: restarts on each arrival and saturates at the limit.
// Assumes: limit may change at any time; expiry compares against the live value.
module cke_idle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             txn_arrive,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Count idle cycles since the last arrival, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || txn_arrive) cnt <= '0;
        else if (cnt < limit)            cnt <= cnt + 1'b1;
    end

    // Expiry once the count has reached the programmed limit.
    always_comb expired = (cnt >= limit);

    assert_arrival_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && txn_arrive && limit != '0) |=> (!expired || limit == '0));
endmodule

// File: rtl/cke_rank_fsm.sv
// Power-down state machine of one rank: picks the flavour, handles the
// precharge handshake, hybrid deepening, exit delays and self-refresh.
// Assumes: en already combines the release latch and population bit.
module cke_rank_fsm
    import cke_pd_pkg::*;
#(
    parameter int T_XP    = 4,
    parameter int T_XPDLL = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] mode,
    input  logic       idle_expired,
    input  logic       txn_arrive,
    input  logic       txn_pending,
    input  logic       pages_expired,
    input  logic       refresh_req,
    input  logic       sref_go,
    input  logic       pre_ack,
    output logic       cke,
    output logic       issue_ok,
    output logic       pre_req,
    output logic       dll_off,
    output logic       in_sref
);
    localparam int LONG_DLY = T_XP + T_XPDLL;
    localparam int WCNT_W   = $clog2(LONG_DLY + 1);
    localparam logic [WCNT_W-1:0] LOAD_S = WCNT_W'(T_XP - 1);
    localparam logic [WCNT_W-1:0] LOAD_L = WCNT_W'(LONG_DLY - 1);

    rank_st_e          st, st_n;
    logic [WCNT_W-1:0] wcnt, wcnt_n;
    logic              deepen, deepen_n, tgt_dll, tgt_dll_n;
    logic              wake, hybrid;

    // Next-state selection for the rank.
    always_comb begin
        st_n      = st;
        wcnt_n    = wcnt;
        deepen_n  = deepen;
        tgt_dll_n = tgt_dll;
        wake      = txn_arrive | txn_pending | refresh_req;
        hybrid    = (mode == PD_MODE_ACT2PRE) || (mode == PD_MODE_ACT2DLL);
        if (!en) begin
            st_n = RK_OFF;
        end else if (st == RK_OFF) begin
            st_n = RK_UP;
        end else if (st == RK_SREF) begin
            if (!sref_go) begin
                st_n = RK_WAKE; wcnt_n = LOAD_L; deepen_n = 1'b0;
            end
        end else if (sref_go) begin
            st_n = RK_SREF;
        end else begin
            case (st)
                RK_UP: if (idle_expired && !wake) begin
                    case (mode)
                        PD_MODE_ACTIVE, PD_MODE_ACT2PRE, PD_MODE_ACT2DLL: st_n = RK_APD;
                        PD_MODE_PRECH:  begin st_n = RK_PRE; tgt_dll_n = 1'b0; end
                        PD_MODE_DLLOFF: begin st_n = RK_PRE; tgt_dll_n = 1'b1; end
                        default: st_n = RK_UP;
                    endcase
                end
                RK_PRE: begin
                    if (txn_arrive || refresh_req) st_n = RK_UP;
                    else if (pre_ack)              st_n = tgt_dll ? RK_DLL : RK_PPD;
                end
                RK_APD: begin
                    if (wake) begin
                        st_n = RK_WAKE; wcnt_n = LOAD_S; deepen_n = 1'b0;
                    end else if (hybrid && pages_expired) begin
                        st_n = RK_WAKE; wcnt_n = LOAD_S; deepen_n = 1'b1;
                        tgt_dll_n = (mode == PD_MODE_ACT2DLL);
                    end
                end
                RK_PPD: if (wake) begin
                    st_n = RK_WAKE; wcnt_n = LOAD_S; deepen_n = 1'b0;
                end
                RK_DLL: if (wake) begin
                    st_n = RK_WAKE; wcnt_n = LOAD_L; deepen_n = 1'b0;
                end
                RK_WAKE: begin
                    if (wcnt == '0) st_n = (deepen && !wake) ? RK_PRE : RK_UP;
                    else            wcnt_n = wcnt - 1'b1;
                    if (txn_arrive) deepen_n = 1'b0;
                end
                default: st_n = RK_UP;
            endcase
        end
    end

    // State registers of the rank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= RK_OFF; wcnt <= '0; deepen <= 1'b0; tgt_dll <= 1'b0;
        end else begin
            st <= st_n; wcnt <= wcnt_n; deepen <= deepen_n; tgt_dll <= tgt_dll_n;
        end
    end

    // Output decode, gated by the rank enable.
    always_comb begin
        cke      = en && (st == RK_UP || st == RK_PRE || st == RK_WAKE);
        issue_ok = en && (st == RK_UP);
        pre_req  = en && (st == RK_PRE);
        dll_off  = en && (st == RK_DLL);
        in_sref  = en && (st == RK_SREF);
    end

    assert_hold_unreleased_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!cke && !issue_ok));
    assert_ack_drops_cke_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pre_req && pre_ack && !txn_arrive && !refresh_req && !sref_go && en)
        |=> (!cke || !en));
    assert_wake_blocks_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cke && st != RK_OFF && st != RK_SREF && txn_arrive && !sref_go)
        |=> (!en || (cke && !issue_ok)));
    assert_fall_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $fell(cke)) |-> ($past(idle_expired) || $past(sref_go)));
endmodule

// File: rtl/cke_pd_ctrl.sv
// Top of the rank clock-enable power-down controller: release latch,
// self-refresh gate, refresh gathering and one timer plus FSM per rank.
// Assumes: pulses and levels are synchronous to clk.
module cke_pd_ctrl #(
    parameter int NUM_RANKS = 4,
    parameter int IDLE_W    = 8,
    parameter int T_XP      = 4,
    parameter int T_XPDLL   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_cke_release,
    input  logic [2:0]           cfg_pd_mode,
    input  logic [IDLE_W-1:0]    cfg_idle_limit,
    input  logic [NUM_RANKS-1:0] rank_populated,
    input  logic [NUM_RANKS-1:0] txn_arrive,
    input  logic [NUM_RANKS-1:0] txn_pending,
    input  logic [NUM_RANKS-1:0] pages_closed_all,
    input  logic                 refresh_req,
    output logic                 refresh_ready,
    input  logic                 pkg_deep_idle,
    output logic [NUM_RANKS-1:0] pre_all_req,
    input  logic [NUM_RANKS-1:0] pre_all_ack,
    output logic [NUM_RANKS-1:0] cke,
    output logic [NUM_RANKS-1:0] issue_ok,
    output logic [NUM_RANKS-1:0] dll_off_sel,
    output logic                 sref_active
);
    logic                 released;
    logic                 sref_go;
    logic [NUM_RANKS-1:0] rank_en, expired, in_sref;

    // Sticky release of clock-enable after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)               released <= 1'b0;
        else if (cfg_cke_release) released <= 1'b1;
    end

    // Enables, self-refresh gate and refresh gathering.
    always_comb begin
        rank_en       = {NUM_RANKS{released}} & rank_populated;
        sref_go       = pkg_deep_idle && (txn_pending == '0) && (txn_arrive == '0);
        refresh_ready = refresh_req && ((issue_ok | ~rank_en) == {NUM_RANKS{1'b1}});
        sref_active   = |in_sref;
    end

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        cke_idle_timer #(.CNT_W(IDLE_W)) u_timer (
            .clk(clk), .rst_n(rst_n), .en(rank_en[r]), .txn_arrive(txn_arrive[r]),
            .limit(cfg_idle_limit), .expired(expired[r])
        );
        cke_rank_fsm #(.T_XP(T_XP), .T_XPDLL(T_XPDLL)) u_fsm (
            .clk(clk), .rst_n(rst_n), .en(rank_en[r]), .mode(cfg_pd_mode),
            .idle_expired(expired[r]), .txn_arrive(txn_arrive[r]),
            .txn_pending(txn_pending[r]), .pages_expired(pages_closed_all[r]),
            .refresh_req(refresh_req), .sref_go(sref_go), .pre_ack(pre_all_ack[r]),
            .cke(cke[r]), .issue_ok(issue_ok[r]), .pre_req(pre_all_req[r]),
            .dll_off(dll_off_sel[r]), .in_sref(in_sref[r])
        );
    end

    assert_ready_all_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_ready |-> ((cke | ~rank_en) == {NUM_RANKS{1'b1}}));
    assert_unpopulated_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cke | pre_all_req | dll_off_sel) & ~rank_populated) == '0);
endmodule

// File: tb/cke_pd_ctrl_tb_top.sv
module cke_pd_ctrl_tb_top;
    localparam int NR = 2;
    localparam int TXP = 3;
    localparam int TXPDLL = 10;
    localparam int LD_S = TXP - 1;
    localparam int LD_L = TXP + TXPDLL - 1;
    // model state codes
    localparam int S_OFF = 0, S_UP = 1, S_PRE = 2, S_APD = 3, S_PPD = 4, S_DLL = 5, S_WAKE = 6, S_SREF = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rel = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [7:0] limit = 8'd15;
    logic [NR-1:0] pop = '1, arr = '0, pend = '0, pgs = '0, ack = '0;
    logic rreq = 1'b0, deep = 1'b0, rrdy, sref;
    logic [NR-1:0] cke, iok, preq, dll;

    int vectors = 0, errors = 0, ack_mode = 1;
    int ms[NR], mc[NR], mw[NR], md[NR], mt[NR];
    int mrel = 0;

    always #2.5 clk = ~clk;

    cke_pd_ctrl #(.NUM_RANKS(NR), .IDLE_W(8), .T_XP(TXP), .T_XPDLL(TXPDLL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cke_release(rel), .cfg_pd_mode(mode),
        .cfg_idle_limit(limit), .rank_populated(pop), .txn_arrive(arr),
        .txn_pending(pend), .pages_closed_all(pgs), .refresh_req(rreq),
        .refresh_ready(rrdy), .pkg_deep_idle(deep), .pre_all_req(preq),
        .pre_all_ack(ack), .cke(cke), .issue_ok(iok), .dll_off_sel(dll),
        .sref_active(sref)
    );

    function automatic bit m_en(int r);
        return (mrel != 0) && pop[r];
    endfunction

    function automatic logic [NR-1:0] exp_cke();
        logic [NR-1:0] v;
        for (int r = 0; r < NR; r++)
            v[r] = m_en(r) && (ms[r] == S_UP || ms[r] == S_PRE || ms[r] == S_WAKE);
        return v;
    endfunction

    function automatic logic [NR-1:0] exp_st(int code);
        logic [NR-1:0] v;
        for (int r = 0; r < NR; r++) v[r] = m_en(r) && (ms[r] == code);
        return v;
    endfunction

    function automatic bit exp_rdy();
        bit ok = rreq;
        for (int r = 0; r < NR; r++) if (m_en(r) && ms[r] != S_UP) ok = 0;
        return ok;
    endfunction

    // reference model advance, from the requirements
    task automatic model_step();
        bit sg, wk, ex, hyb;
        int ns, nw, nd, nt;
        if (!rst_n) begin
            for (int r = 0; r < NR; r++) begin ms[r] = S_OFF; mc[r] = 0; mw[r] = 0; md[r] = 0; mt[r] = 0; end
            mrel = 0;
            return;
        end
        sg = deep && (pend == '0) && (arr == '0);
        hyb = (mode == 3'd4) || (mode == 3'd5);
        for (int r = 0; r < NR; r++) begin
            ns = ms[r]; nw = mw[r]; nd = md[r]; nt = mt[r];
            wk = arr[r] || pend[r] || rreq;
            ex = (mc[r] >= limit);
            if (!m_en(r)) ns = S_OFF;
            else if (ms[r] == S_OFF) ns = S_UP;
            else if (ms[r] == S_SREF) begin
                if (!sg) begin ns = S_WAKE; nw = LD_L; nd = 0; end
            end else if (sg) ns = S_SREF;
            else begin
                case (ms[r])
                    S_UP: if (ex && !wk) begin
                        if (mode == 1 || mode == 4 || mode == 5) ns = S_APD;
                        else if (mode == 2) begin ns = S_PRE; nt = 0; end
                        else if (mode == 3) begin ns = S_PRE; nt = 1; end
                    end
                    S_PRE: if (arr[r] || rreq) ns = S_UP; else if (ack[r]) ns = mt[r] ? S_DLL : S_PPD;
                    S_APD: if (wk) begin ns = S_WAKE; nw = LD_S; nd = 0; end
                           else if (hyb && pgs[r]) begin ns = S_WAKE; nw = LD_S; nd = 1; nt = (mode == 5); end
                    S_PPD: if (wk) begin ns = S_WAKE; nw = LD_S; nd = 0; end
                    S_DLL: if (wk) begin ns = S_WAKE; nw = LD_L; nd = 0; end
                    default: begin
                        if (mw[r] == 0) ns = (md[r] && !wk) ? S_PRE : S_UP;
                        else nw = mw[r] - 1;
                        if (arr[r]) nd = 0;
                    end
                endcase
            end
            mc[r] = (!m_en(r) || arr[r]) ? 0 : ((mc[r] < limit) ? mc[r] + 1 : mc[r]);
            ms[r] = ns; mw[r] = nw; md[r] = nd; mt[r] = nt;
        end
        if (rel) mrel = 1;
    endtask

    task automatic cmp(input string tag);
        vectors++;
        if (cke !== exp_cke() || iok !== exp_st(S_UP) || preq !== exp_st(S_PRE) ||
            dll !== exp_st(S_DLL) || rrdy !== exp_rdy() || sref !== (exp_st(S_SREF) != '0)) begin
            errors++;
            $display("FAIL %s: cke=%b iok=%b pre=%b dll=%b rdy=%b sref=%b expected cke=%b iok=%b pre=%b dll=%b rdy=%b sref=%b",
                tag, cke, iok, preq, dll, rrdy, sref, exp_cke(), exp_st(S_UP), exp_st(S_PRE),
                exp_st(S_DLL), exp_rdy(), exp_st(S_SREF) != '0);
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
        vectors++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // one clock: ack from model, advance model, compare after the edge
    task automatic tick(input string tag);
        for (int r = 0; r < NR; r++)
            ack[r] = m_en(r) && ms[r] == S_PRE &&
                     (ack_mode == 1 || (ack_mode == 2 && ($urandom % 3) == 0));
        model_step();
        @(negedge clk);
        cmp(tag);
        arr = '0;
        rel = 1'b0;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        run(3, "R1");
        rst_n = 1'b1;
        chk("R1 reset cke", {6'd0, cke}, 8'd0);
        mode = 3'd1;
        run(30, "R1");
        chk("R1 unreleased cke", {6'd0, cke}, 8'd0);
        // R2: only rank 0 populated
        pop = 2'b01; rel = 1'b1;
        run(40, "R2");
        chk("R2 rank1 cke", {7'd0, cke[1]}, 8'd0);
        chk("R5 rank0 down", {7'd0, cke[0]}, 8'd0);
        // R8: arrival wakes with short delay
        arr = 2'b01;
        tick("R8");
        chk("R8 cke up", {7'd0, cke[0]}, 8'd1);
        chk("R8 issue blocked", {7'd0, iok[0]}, 8'd0);
        run(TXP, "R8");
        chk("R8 issue after exit", {7'd0, iok[0]}, 8'd1);
        // R4 and R11: no power-down
        pop = 2'b11; mode = 3'd0;
        run(60, "R4");
        chk("R4 cke held", {6'd0, cke}, 8'h03);
        mode = 3'd6;
        run(40, "R11");
        chk("R11 code 6 cke held", {6'd0, cke}, 8'h03);
        // R6: precharge handshake withheld, then granted
        ack_mode = 0; mode = 3'd2; arr = 2'b11; tick("R6");
        run(20, "R6");
        chk("R6 pre req held", {6'd0, preq}, 8'h03);
        chk("R6 cke kept", {6'd0, cke}, 8'h03);
        ack_mode = 1;
        run(2, "R6");
        chk("R6 cke after ack", {6'd0, cke}, 8'h00);
        mode = 3'd3; arr = 2'b11; tick("R6");
        run(40, "R6");
        chk("R6 dll off", {6'd0, dll}, 8'h03);
        arr = 2'b10; tick("R8");
        run(TXP + 2, "R8");
        chk("R8 long exit blocks", {7'd0, iok[1]}, 8'd0);
        run(TXPDLL, "R8");
        // R7: hybrids
        for (int m = 4; m <= 5; m++) begin
            mode = 3'(m); pgs = 2'b00; arr = 2'b11; tick("R7");
            run(30, "R7");
            pgs = 2'b11;
            run(30, "R7");
            chk("R7 deep state", {6'd0, dll}, (m == 5) ? 8'h03 : 8'h00);
            chk("R7 cke low", {6'd0, cke}, 8'h00);
        end
        // R9: refresh gathering
        pgs = '0; limit = 8'd18; rreq = 1'b1;
        run(TXP + TXPDLL + 4, "R9");
        chk("R9 ready", {7'd0, rrdy}, 8'd1);
        rreq = 1'b0;
        run(4, "R9");
        chk("R9 down again", {6'd0, cke}, 8'h00);
        // R10: self-refresh
        mode = 3'd1; deep = 1'b1;
        run(5, "R10");
        chk("R10 sref", {7'd0, sref}, 8'd1);
        deep = 1'b0;
        run(20, "R10");
        // R3: random mix
        ack_mode = 2;
        for (int i = 0; i < 6000; i++) begin
            if (i % 400 == 0) mode = 3'($urandom % 8);
            if (i % 700 == 0) limit = 8'(15 + $urandom % 8);
            if ($urandom % 900 == 0) pop = 2'($urandom % 4);
            for (int r = 0; r < NR; r++) begin
                arr[r] = ($urandom % 35) == 0;
                pend[r] = ($urandom % 60) == 0;
                if (($urandom % 25) == 0) pgs[r] = ~pgs[r];
            end
            if (!rreq && ($urandom % 300) == 0) rreq = 1'b1;
            else if (rreq && ($urandom % 30) == 0) rreq = 1'b0;
            if (($urandom % 400) == 0) deep = ~deep;
            else if (deep && ($urandom % 50) == 0) deep = 1'b0;
            tick("R3");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule